// File: doc/BRIEF.md
# Interrupt-to-DMA Request Steering Unit

This block receives single-cycle event pulses from sixteen port-input interrupt sources and decides, source by source, whether each event goes to the CPU interrupt controller or to a DMA controller. Each source has two configuration bits that must both be set for DMA steering. When they are, the event queues a trigger for that source's fixed DMA channel. The CPU interrupt is held back until the DMA controller returns a completion tagged with the same channel. A per-source option can drop that interrupt entirely, so the source runs in DMA-only mode.

Events that are not steered set a sticky CPU interrupt pending bit straight away. Software clears pending bits with a write-one-to-clear strobe. The unit also presents a vector address for the lowest-index pending source. This address is the sum of a programmable table base and a fixed offset for that source.

Top module: `irq_dma_steer`

## Requirements
- R1: A source event sampled at clock edge k, with the source's DMA-request and DMA-enable bits both 1 and the source idle, produces `dma_trig` high for exactly the one cycle after edge k+1.
- R2: The trigger carries the source's channel on `dma_chan`. Sources 0..3 use channels 1..4, sources 4..7 use channels 28..31, and sources 8..15 use channels 38..45.
- R3: An event on a source whose DMA-request or DMA-enable bit is 0 sets `irq_pend[i]` at edge k and produces no trigger.
- R4: A DMA-steered event leaves `irq_pend[i]` clear. `irq_pend[i]` is set at the edge that samples `dma_done` high with `dma_done_chan` equal to the source's channel.
- R5: With `cfg_no_irq[i]`=1, completion for a steered source returns the source to idle without setting `irq_pend[i]`.
- R6: A repeat event on a source that is queued or awaiting completion is ignored and gives no second trigger. After completion, a new event triggers again.
- R7: When several steered sources fire in the same cycle, their triggers go out one per cycle on consecutive cycles, lowest source index first.
- R8: `irq_pend` bits are sticky. A 1 on `irq_clr[i]` clears bit i at the next edge. A set on the same edge wins over the clear. Other bits are unaffected.
- R9: `irq_req` is 1 exactly when any `irq_pend` bit is 1. `irq_vec` equals `tbl_base` plus the offset of the lowest-index pending source, and is 0 when nothing is pending.
- R10: Source offsets are 0x040+4*i for sources 0..3, 0x110+4*(i-4) for sources 4..7, and 0x150+4*(i-8) for sources 8..15. With base 0xC00000, this gives 0xC00040..0xC0016C.
- R11: A completion whose channel belongs to no source awaiting completion changes nothing.
- R12: While `rst_n` is 0, all pending bits, the queued and waiting state, and `dma_trig` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 16 | Per-source event pulses |
| cfg_dma_req | input | 16 | Per-source DMA-request bit |
| cfg_dma_en | input | 16 | Per-source DMA-enable bit |
| cfg_no_irq | input | 16 | Suppress the interrupt after DMA completion |
| tbl_base | input | 24 | Vector table base address |
| irq_clr | input | 16 | Write-one-to-clear strobe for pending bits |
| dma_done | input | 1 | Completion strobe from the DMA controller |
| dma_done_chan | input | 6 | Channel of the completion |
| dma_trig | output | 1 | Single-cycle DMA trigger |
| dma_chan | output | 6 | Channel of the trigger |
| irq_pend | output | 16 | Sticky CPU interrupt pending bits |
| irq_req | output | 1 | Any interrupt pending |
| irq_vec | output | 24 | Vector address of the lowest pending source |

## Verification
Every source is swept through all four combinations of its two steering bits. Each combination is also run with and without the interrupt suppression option, under a different table base. This separates the immediate-interrupt path from the deferred path and exposes any error in the channel or offset maps for each source. A burst with all sixteen sources firing at once checks the trigger ordering. Completions are then returned in reverse order, which moves the lowest pending source on every step and so checks the vector priority. Separate patterns cover a repeat event during the wait, a completion with an unused channel, and a set that collides with a clear on the same edge.

// File: rtl/irqdma_pkg.sv
package irqdma_pkg;
   // Number of sources covered by the fixed channel and offset maps
   localparam int unsigned MAP_SRCS = 16;
   localparam int unsigned MAP_CHW  = 6;
   localparam int unsigned MAP_OFFW = 12;

   // Fixed DMA channel per source
   function automatic logic [MAP_CHW-1:0] src_chan(input int unsigned idx);
      if (idx < 4)      return MAP_CHW'(idx + 1);
      else if (idx < 8) return MAP_CHW'(idx + 24);
      else              return MAP_CHW'(idx + 30);
   endfunction

   // Fixed vector offset per source, relative to the table base
   function automatic logic [MAP_OFFW-1:0] src_vec_off(input int unsigned idx);
      if (idx < 4)      return MAP_OFFW'(32'h040 + 4 * idx);
      else if (idx < 8) return MAP_OFFW'(32'h100 + 4 * idx);
      else              return MAP_OFFW'(32'h130 + 4 * idx);
   endfunction
endpackage

// File: rtl/irqdma_prio_pick.sv
module irqdma_prio_pick #(
   parameter int unsigned N = 16
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   // Lowest index wins
   always_comb begin
      gnt = '0;
      any = 1'b0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req[k]) begin
            gnt    = '0;
            gnt[k] = 1'b1;
            any    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irqdma_done_match.sv
module irqdma_done_match
   import irqdma_pkg::*;
#(
   parameter int unsigned NSRC = 16,
   parameter int unsigned CHW  = 6
) (
   input  logic            done_vld,
   input  logic [CHW-1:0]  done_chan,
   output logic [NSRC-1:0] hit
);
   for (genvar g = 0; g < NSRC; g++) begin : g_cmp
      localparam logic [CHW-1:0] MY_CHAN = CHW'(src_chan(g));
      assign hit[g] = done_vld && (done_chan == MY_CHAN);
   end
endmodule

// File: rtl/irqdma_vec_gen.sv
module irqdma_vec_gen
   import irqdma_pkg::*;
#(
   parameter int unsigned NSRC = 16,
   parameter int unsigned AW   = 24
) (
   input  logic [AW-1:0]   base,
   input  logic [NSRC-1:0] pend,
   output logic            req,
   output logic [AW-1:0]   vec
);
   logic [NSRC-1:0]     sel;
   logic                any;
   logic [MAP_OFFW-1:0] off;

   irqdma_prio_pick #(.N(NSRC)) u_pick (
      .req (pend),
      .gnt (sel),
      .any (any)
   );

   always_comb begin
      off = '0;
      for (int k = 0; k < NSRC; k++) begin
         if (sel[k]) off = off | src_vec_off(k);
      end
   end

   assign req = any;
   assign vec = any ? (base + AW'(off)) : '0;
endmodule

// File: rtl/irq_dma_steer.sv
module irq_dma_steer
   import irqdma_pkg::*;
#(
   parameter int unsigned NSRC = 16,
   parameter int unsigned CHW  = 6,
   parameter int unsigned AW   = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_evt,
   input  logic [NSRC-1:0] cfg_dma_req,
   input  logic [NSRC-1:0] cfg_dma_en,
   input  logic [NSRC-1:0] cfg_no_irq,
   input  logic [AW-1:0]   tbl_base,
   input  logic [NSRC-1:0] irq_clr,
   input  logic            dma_done,
   input  logic [CHW-1:0]  dma_done_chan,
   output logic            dma_trig,
   output logic [CHW-1:0]  dma_chan,
   output logic [NSRC-1:0] irq_pend,
   output logic            irq_req,
   output logic [AW-1:0]   irq_vec
);
   // Elaboration-time parameter checks
   if (NSRC < 1 || NSRC > MAP_SRCS) begin : g_bad_nsrc
      $error("irq_dma_steer: NSRC must lie in 1..16");
   end
   if (CHW < MAP_CHW) begin : g_bad_chw
      $error("irq_dma_steer: CHW too narrow for the channel map");
   end
   if (AW < MAP_OFFW) begin : g_bad_aw
      $error("irq_dma_steer: AW too narrow for the vector offsets");
   end

   logic [NSRC-1:0] queued_q, wait_q, pend_q;
   logic [NSRC-1:0] steer, busy, accept, direct;
   logic [NSRC-1:0] gnt, done_hit, fin, irq_set;
   logic            pick_any;
   logic [CHW-1:0]  chan_d;
   logic            trig_q;
   logic [CHW-1:0]  chan_q;
   logic [CHW-1:0]  chan_lut [NSRC];

   for (genvar g = 0; g < NSRC; g++) begin : g_lut
      assign chan_lut[g] = CHW'(src_chan(g));
   end

   assign steer  = cfg_dma_req & cfg_dma_en;
   assign busy   = queued_q | wait_q;
   assign accept = src_evt & steer & ~busy;
   assign direct = src_evt & ~steer;

   irqdma_prio_pick #(.N(NSRC)) u_trig_pick (
      .req (queued_q),
      .gnt (gnt),
      .any (pick_any)
   );

   irqdma_done_match #(.NSRC(NSRC), .CHW(CHW)) u_done (
      .done_vld  (dma_done),
      .done_chan (dma_done_chan),
      .hit       (done_hit)
   );

   assign fin     = done_hit & wait_q;
   assign irq_set = direct | (fin & ~cfg_no_irq);

   always_comb begin
      chan_d = '0;
      for (int k = 0; k < NSRC; k++) begin
         if (gnt[k]) chan_d = chan_d | chan_lut[k];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         queued_q <= '0;
         wait_q   <= '0;
         pend_q   <= '0;
         trig_q   <= 1'b0;
         chan_q   <= '0;
      end else begin
         queued_q <= (queued_q & ~gnt) | accept;
         wait_q   <= (wait_q & ~fin) | gnt;
         pend_q   <= (pend_q & ~irq_clr) | irq_set;
         trig_q   <= pick_any;
         chan_q   <= chan_d;
      end
   end

   irqdma_vec_gen #(.NSRC(NSRC), .AW(AW)) u_vec (
      .base (tbl_base),
      .pend (pend_q),
      .req  (irq_req),
      .vec  (irq_vec)
   );

   assign dma_trig = trig_q;
   assign dma_chan = chan_q;
   assign irq_pend = pend_q;

   // R2
   trig_chan_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_trig |-> (dma_chan != '0));

   for (genvar g = 0; g < NSRC; g++) begin : g_chk
      // R8
      pend_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(irq_pend[g]) |-> $past(irq_clr[g]));
      // R4
      pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_pend[g]) |->
            ($past(src_evt[g] && !(cfg_dma_req[g] && cfg_dma_en[g])) ||
             $past(done_hit[g] && !cfg_no_irq[g])));
      // R6
      state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(queued_q[g] && wait_q[g]));
      // R1
      wait_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(wait_q[g]) |-> (dma_trig && dma_chan == chan_lut[g]));
   end
endmodule

// File: tb/tb_irq_dma_steer.sv
module tb_irq_dma_steer;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] src_evt, cfg_dma_req, cfg_dma_en, cfg_no_irq, irq_clr;
   logic [23:0] tbl_base;
   logic        dma_done;
   logic [5:0]  dma_done_chan;
   logic        dma_trig;
   logic [5:0]  dma_chan;
   logic [15:0] irq_pend;
   logic        irq_req;
   logic [23:0] irq_vec;

   int checks = 0;
   int errors = 0;
   bit ended  = 0;

   always #5 clk = ~clk;

   irq_dma_steer dut (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .cfg_dma_req(cfg_dma_req),
      .cfg_dma_en(cfg_dma_en), .cfg_no_irq(cfg_no_irq), .tbl_base(tbl_base),
      .irq_clr(irq_clr), .dma_done(dma_done), .dma_done_chan(dma_done_chan),
      .dma_trig(dma_trig), .dma_chan(dma_chan), .irq_pend(irq_pend),
      .irq_req(irq_req), .irq_vec(irq_vec)
   );

   function automatic logic [5:0] exp_chan(input int i);
      if (i < 4) return 6'(1 + i);
      if (i < 8) return 6'(28 + (i - 4));
      return 6'(38 + (i - 8));
   endfunction

   function automatic logic [23:0] exp_off(input int i);
      if (i < 4) return 24'(24'h040 + 4 * i);
      if (i < 8) return 24'(24'h110 + 4 * (i - 4));
      return 24'(24'h150 + 4 * (i - 8));
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(negedge clk);
   endtask

   task automatic send_done(input logic [5:0] ch);
      dma_done = 1'b1; dma_done_chan = ch;
      tick;
      dma_done = 1'b0; dma_done_chan = '0;
   endtask

   task automatic one_case(input int i, input bit rq, input bit en, input bit noirq);
      logic [15:0] bit_i;
      bit_i = 16'(1) << i;
      cfg_dma_req = rq ? bit_i : '0;
      cfg_dma_en  = en ? bit_i : '0;
      cfg_no_irq  = noirq ? bit_i : '0;
      tbl_base    = (rq && en) ? 24'hC00000 : 24'(24'h400000 + i * 24'h1000);
      src_evt = bit_i;
      tick;
      src_evt = '0;
      if (!(rq && en)) begin
         chk("R3 pend set", irq_pend, bit_i);
         chk("R3 no trig", dma_trig, 0);
         chk("R9 req", irq_req, 1);
         chk("R10 vec", irq_vec, tbl_base + exp_off(i));
         tick;
         chk("R3 no trig later", dma_trig, 0);
         irq_clr = bit_i;
         tick;
         irq_clr = '0;
         chk("R8 cleared", irq_pend, 0);
         chk("R9 idle vec", irq_vec, 0);
      end else begin
         chk("R4 deferred", irq_pend, 0);
         chk("R1 not yet", dma_trig, 0);
         tick;
         chk("R1 trig", dma_trig, 1);
         chk("R2 chan", dma_chan, exp_chan(i));
         src_evt = bit_i;
         tick;
         src_evt = '0;
         chk("R1 single pulse", dma_trig, 0);
         tick;
         chk("R6 repeat ignored", dma_trig, 0);
         chk("R4 still deferred", irq_pend, 0);
         send_done(exp_chan(i));
         if (noirq) chk("R5 suppressed", irq_pend, 0);
         else begin
            chk("R4 after done", irq_pend, bit_i);
            chk("R10 vec", irq_vec, 24'hC00000 + exp_off(i));
         end
         src_evt = bit_i;
         tick;
         src_evt = '0;
         tick;
         chk("R6 retrigger", dma_trig, 1);
         send_done(exp_chan(i));
         irq_clr = '1;
         tick;
         irq_clr = '0;
      end
   endtask

   initial begin
      rst_n = 1'b0;
      src_evt = '0; cfg_dma_req = '0; cfg_dma_en = '0; cfg_no_irq = '0;
      irq_clr = '0; tbl_base = 24'hC00000; dma_done = 1'b0; dma_done_chan = '0;
      repeat (3) tick;
      chk("R12 pend", irq_pend, 0);
      chk("R12 trig", dma_trig, 0);
      chk("R12 req", irq_req, 0);
      rst_n = 1'b1;
      tick;

      // Per-source sweep over the steering bits and suppression option
      for (int i = 0; i < 16; i++)
         for (int m = 0; m < 8; m++)
            one_case(i, m[0], m[1], m[2]);

      // R11: completion with no source waiting
      cfg_dma_req = '1; cfg_dma_en = '1; cfg_no_irq = '0; tbl_base = 24'hC00000;
      send_done(6'd1);
      chk("R11 unmatched", irq_pend, 0);
      send_done(6'd0);
      chk("R11 unmapped", irq_pend, 0);

      // R7: all sources at once
      src_evt = '1;
      tick;
      src_evt = '0;
      for (int k = 0; k < 16; k++) begin
         tick;
         chk("R7 burst trig", dma_trig, 1);
         chk("R7 burst order", dma_chan, exp_chan(k));
      end
      tick;
      chk("R7 burst end", dma_trig, 0);
      for (int k = 15; k >= 0; k--) begin
         send_done(exp_chan(k));
         chk("R9 lowest pending vec", irq_vec, 24'hC00000 + exp_off(k));
      end
      chk("R4 all pending", irq_pend, 16'hFFFF);
      irq_clr = 16'h0008;
      tick;
      irq_clr = '0;
      chk("R8 single clear", irq_pend, 16'hFFF7);
      irq_clr = '1;
      tick;
      irq_clr = '0;

      // R8: set wins over a clear on the same edge
      cfg_dma_req = '0; cfg_dma_en = '0;
      src_evt = 16'h0020;
      tick;
      src_evt = 16'h0020; irq_clr = 16'h0020;
      tick;
      src_evt = '0; irq_clr = '0;
      chk("R8 set wins", irq_pend, 16'h0020);

      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule